// File: doc/BRIEF.md
# Four-Channel PWM Generator with Shared Dividers

This block produces four pulse-width-modulated outputs from four shared timebases. Each timebase pairs a 16-bit prescaler with an 8-bit phase counter. The prescaler produces one tick every D input clocks, where D is that timebase's divide value. The phase counter advances once per tick, so one PWM period lasts 256 ticks, or 256·D clocks.

Each output channel chooses any one of the four timebases and compares that timebase's phase with its own 8-bit duty value. The output is high while the phase is below the duty value. A per-channel bypass bit holds the output high for a full-duty waveform. A per-channel enable gates the output, and a per-timebase run bit starts or stops each counter.

Software reaches all settings through a small memory-mapped port. Writes complete in a single cycle. Reads return data one cycle after the address is presented. New settings act at once: a running period is not finished first, so a sequence of writes passes through intermediate combinations.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every register reads zero and all four outputs are low.
- R2: Registers read back their last written value, and bits that have no function read as zero.
  - Control register at 0x000: output enable of channel c at bit c, bypass of channel c at bit 8+c.
  - Run register at 0x004: run of timebase c at bit c.
  - Divide register of timebase c at 0x008+4c: bits 15:0.
  - Duty register of channel c at 0x018+4c: duty at bits 7:0, timebase select at bits 9:8.
- R3: A write to any other byte address, including addresses that are not word-aligned, changes no register. A read of such an address returns zero.
- R4: Suppose a channel is enabled, its bypass bit is clear, and it follows a running timebase with divide value D > 0. Over any 256·D consecutive clocks, its output is then high for exactly N·D clocks, where N is its duty value.
- R5: The select field of a channel's duty register (bits 9:8) picks which timebase's phase that channel compares against.
- R6: An enabled channel with its bypass bit set drives its output constantly high, whatever its duty value.
- R7: A channel whose enable bit is clear drives its output low, even when its bypass bit is set.
- R8: A timebase that is not running, or whose divide value is zero, holds phase 0. A channel that follows it is then constantly high if N > 0 and constantly low if N = 0.
- R9: A register write captured at clock edge t shows on the outputs after edge t+1, with no wait for the current period to end.
- R10: Read data presented with an address before edge t is valid on the read-data port after edge t.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address presented in the previous cycle |
| pwm_out | output | 4 | PWM outputs, bit c is channel c |

## Verification
The bench builds the block with its default sizes: four channels, 16-bit divide values and an 8-bit phase. At run time it programs divide values 1 to 4 into the four timebases, so a full period lasts between 256 and 1024 clocks. Short periods make it affordable to measure the high time over whole periods for every timebase select and a spread of duty values, including 0 and 255. They also leave room for the bypass, disable and idle-timebase corners, and for exact one-cycle timing checks on register writes and reads.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Byte offsets of the register groups
  localparam int CTRL_OFF  = 0;
  localparam int RUN_OFF   = 4;
  localparam int DIV_BASE  = 8;
  localparam int DUTY_BASE = 24;
  // Field positions
  localparam int BYP_LSB   = 8;
  localparam int SEL_LSB   = 8;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int DIV_W   = 16,
  parameter int PHASE_W = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              bus_wr,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [DATA_W-1:0]                 bus_wdata,
  output logic [DATA_W-1:0]                 bus_rdata,
  output logic [NUM_CH-1:0]                 ch_en,
  output logic [NUM_CH-1:0]                 ch_byp,
  output logic [NUM_CH-1:0]                 tb_run,
  output logic [NUM_CH-1:0][DIV_W-1:0]      tb_div,
  output logic [NUM_CH-1:0][PHASE_W-1:0]    ch_duty,
  output logic [NUM_CH-1:0][$clog2(NUM_CH)-1:0] ch_sel
);
  localparam int SEL_W = $clog2(NUM_CH);

  logic              addr_hit;
  logic [DATA_W-1:0] rd_next;

  // Read decode
  always_comb begin
    rd_next  = '0;
    addr_hit = 1'b0;
    if (bus_addr == ADDR_W'(CTRL_OFF)) begin
      addr_hit = 1'b1;
      rd_next[NUM_CH-1:0]        = ch_en;
      rd_next[BYP_LSB +: NUM_CH] = ch_byp;
    end
    if (bus_addr == ADDR_W'(RUN_OFF)) begin
      addr_hit = 1'b1;
      rd_next[NUM_CH-1:0] = tb_run;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == ADDR_W'(DIV_BASE + 4*c)) begin
        addr_hit = 1'b1;
        rd_next[DIV_W-1:0] = tb_div[c];
      end
      if (bus_addr == ADDR_W'(DUTY_BASE + 4*c)) begin
        addr_hit = 1'b1;
        rd_next[PHASE_W-1:0]      = ch_duty[c];
        rd_next[SEL_LSB +: SEL_W] = ch_sel[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // Write path
  always_ff @(posedge clk) begin
    if (rst) begin
      ch_en   <= '0;
      ch_byp  <= '0;
      tb_run  <= '0;
      tb_div  <= '0;
      ch_duty <= '0;
      ch_sel  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_W'(CTRL_OFF)) begin
        ch_en  <= bus_wdata[NUM_CH-1:0];
        ch_byp <= bus_wdata[BYP_LSB +: NUM_CH];
      end
      if (bus_addr == ADDR_W'(RUN_OFF))
        tb_run <= bus_wdata[NUM_CH-1:0];
      for (int c = 0; c < NUM_CH; c++) begin
        if (bus_addr == ADDR_W'(DIV_BASE + 4*c))
          tb_div[c] <= bus_wdata[DIV_W-1:0];
        if (bus_addr == ADDR_W'(DUTY_BASE + 4*c)) begin
          ch_duty[c] <= bus_wdata[PHASE_W-1:0];
          ch_sel[c]  <= bus_wdata[SEL_LSB +: SEL_W];
        end
      end
    end
  end

  assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !addr_hit |=> (bus_rdata == '0));

  assert_run_write_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(RUN_OFF)) |=> (tb_run == $past(bus_wdata[NUM_CH-1:0])));
endmodule

// File: rtl/pwm_divider.sv
module pwm_divider #(
  parameter int DIV_W   = 16,
  parameter int PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [DIV_W-1:0]   div_val,
  output logic [PHASE_W-1:0] phase
);
  logic [DIV_W-1:0] pre;
  logic             active;
  logic             tick;

  assign active = run && (div_val != '0);
  // Using >= lets a shrinking divide value take effect at once
  assign tick   = active && (pre >= div_val - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      pre   <= '0;
      phase <= '0;
    end else if (tick) begin
      pre   <= '0;
      phase <= phase + PHASE_W'(1);
    end else begin
      pre   <= pre + DIV_W'(1);
    end
  end

  assert_idle_phase_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !active |=> (phase == '0));

  assert_phase_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (active && !tick) |=> $stable(phase));

  assert_pre_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (active && $stable(div_val)) |-> (pre < div_val));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int NUM_CH  = 4,
  parameter int PHASE_W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           en,
  input  logic                           byp,
  input  logic [PHASE_W-1:0]             duty,
  input  logic [$clog2(NUM_CH)-1:0]      sel,
  input  logic [NUM_CH-1:0][PHASE_W-1:0] phases,
  output logic                           pwm
);
  logic [PHASE_W-1:0] cur_phase;

  assign cur_phase = phases[sel];

  always_ff @(posedge clk) begin
    if (rst) pwm <= 1'b0;
    else     pwm <= en && (byp || (cur_phase < duty));
  end

  assert_disabled_low_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm);

  assert_bypass_high_R6: assert property (@(posedge clk) disable iff (rst)
    (en && byp) |=> pwm);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NUM_CH  = 4,
  parameter int DIV_W   = 16,
  parameter int PHASE_W = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int SEL_W = $clog2(NUM_CH);

  logic [NUM_CH-1:0]               ch_en;
  logic [NUM_CH-1:0]               ch_byp;
  logic [NUM_CH-1:0]               tb_run;
  logic [NUM_CH-1:0][DIV_W-1:0]    tb_div;
  logic [NUM_CH-1:0][PHASE_W-1:0]  ch_duty;
  logic [NUM_CH-1:0][SEL_W-1:0]    ch_sel;
  logic [NUM_CH-1:0][PHASE_W-1:0]  phases;

  pwm_regs #(
    .NUM_CH(NUM_CH), .DIV_W(DIV_W), .PHASE_W(PHASE_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_en(ch_en), .ch_byp(ch_byp), .tb_run(tb_run), .tb_div(tb_div),
    .ch_duty(ch_duty), .ch_sel(ch_sel)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_tb
    pwm_divider #(.DIV_W(DIV_W), .PHASE_W(PHASE_W)) u_div (
      .clk(clk), .rst(rst), .run(tb_run[g]), .div_val(tb_div[g]), .phase(phases[g])
    );
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_channel #(.NUM_CH(NUM_CH), .PHASE_W(PHASE_W)) u_ch (
      .clk(clk), .rst(rst), .en(ch_en[g]), .byp(ch_byp[g]),
      .duty(ch_duty[g]), .sel(ch_sel[g]), .phases(phases), .pwm(pwm_out[g])
    );
  end
endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pwm_bank u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // Count high cycles of each output over a window
  task automatic measure(input int win, output int cnt [NCH]);
    for (int c = 0; c < NCH; c++) cnt[c] = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) cnt[c] += int'(pwm_out[c]);
    end
  endtask

  function automatic logic [31:0] reg_mask(input int idx);
    // idx 0 control, 1 run, 2..5 divide, 6..9 duty
    if (idx == 0) return 32'h0000_0F0F;
    if (idx == 1) return 32'h0000_000F;
    if (idx < 6)  return 32'h0000_FFFF;
    return 32'h0000_03FF;
  endfunction

  function automatic logic [7:0] reg_addr(input int idx);
    if (idx == 0) return 8'h00;
    if (idx == 1) return 8'h04;
    if (idx < 6)  return 8'(8 + 4*(idx-2));
    return 8'(24 + 4*(idx-6));
  endfunction

  function automatic int nval(input int i);
    case (i % 5)
      0: return 0;
      1: return 1;
      2: return 37;
      3: return 128;
      default: return 255;
    endcase
  endfunction

  initial begin
    logic [31:0] d;
    int cnt [NCH];
    do_reset();

    // R1: reset state
    for (int i = 0; i < 10; i++) begin
      rd(reg_addr(i), d);
      check("R1 reg after reset", d, 0);
    end
    check("R1 outputs after reset", pwm_out, 0);

    // R2 / R10: readback with masks
    for (int i = 0; i < 10; i++) begin
      wr(reg_addr(i), 32'hFFFF_FFFF);
      rd(reg_addr(i), d);
      check("R2 all-ones readback", d, reg_mask(i));
      wr(reg_addr(i), 32'hA5A5_5A5A);
      rd(reg_addr(i), d);
      check("R2 pattern readback", d, 32'hA5A5_5A5A & reg_mask(i));
    end
    // R10: data valid exactly one edge after the address
    @(negedge clk); bus_addr = 8'h04;
    @(negedge clk); check("R10 read latency", bus_rdata, 32'h0000_000A);

    // R3: unmapped and misaligned writes ignored, reads zero
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h06, 32'hFFFF_FFFF);
    wr(8'h09, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    for (int i = 0; i < 10; i++) begin
      rd(reg_addr(i), d);
      check("R3 regs unchanged", d, 32'hA5A5_5A5A & reg_mask(i));
    end
    rd(8'h28, d); check("R3 unmapped read", d, 0);
    rd(8'h06, d); check("R3 misaligned read", d, 0);

    // R4/R5 sweep: timebase t has divide value t+1
    do_reset();
    for (int t = 0; t < NCH; t++) wr(8'(8 + 4*t), 32'(t + 1));
    wr(8'h04, 32'h0000_000F);
    wr(8'h00, 32'h0000_000F);
    for (int s = 0; s < NCH; s++) begin
      for (int k = 0; k < 5; k++) begin
        for (int c = 0; c < NCH; c++)
          wr(8'(24 + 4*c), (32'(s) << 8) | 32'(nval(k + c)));
        repeat (4) @(negedge clk);
        measure(256 * (s + 1), cnt);
        for (int c = 0; c < NCH; c++)
          check("R4 R5 high time per period", cnt[c], nval(k + c) * (s + 1));
      end
    end

    // R6: bypass forces high
    wr(8'h18, 32'h0000_0000);
    wr(8'h00, 32'h0000_010F);
    repeat (2) @(negedge clk);
    measure(256, cnt);
    check("R6 bypass high", cnt[0], 256);

    // R7: disabled channel low even with bypass
    wr(8'h18, 32'h0000_00FF);
    wr(8'h00, 32'h0000_0F0E);
    repeat (2) @(negedge clk);
    measure(256, cnt);
    check("R7 disabled low", cnt[0], 0);
    check("R7 bypassed neighbour stays high", cnt[1], 256);

    // R8: stopped timebase 0, zero-divide timebase 1
    wr(8'h00, 32'h0000_000F);
    wr(8'h04, 32'h0000_000E);
    wr(8'h0C, 32'h0000_0000);
    wr(8'h18, 32'h0000_0005);   // ch0 -> tb0, N=5
    wr(8'h1C, 32'h0000_0000);   // ch1 -> tb0, N=0
    wr(8'h20, 32'h0000_0103);   // ch2 -> tb1, N=3
    wr(8'h24, 32'h0000_0100);   // ch3 -> tb1, N=0
    repeat (2) @(negedge clk);
    measure(300, cnt);
    check("R8 stopped tb, N>0", cnt[0], 300);
    check("R8 stopped tb, N=0", cnt[1], 0);
    check("R8 zero divide, N>0", cnt[2], 300);
    check("R8 zero divide, N=0", cnt[3], 0);

    // R9: write to output latency
    wr(8'h18, 32'h0000_0000);
    repeat (2) @(negedge clk);
    check("R9 before write", pwm_out[0], 0);
    bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h0000_0001;
    @(negedge clk);             // edge t captured the write
    bus_wr = 1'b0;
    check("R9 after edge t", pwm_out[0], 0);
    @(negedge clk);             // edge t+1 updated the output
    check("R9 after edge t+1", pwm_out[0], 1);

    // R9: divide change applies within the running period
    wr(8'h08, 32'h0000_0002);
    wr(8'h04, 32'h0000_000F);
    wr(8'h18, 32'h0000_0040);
    repeat (100) @(negedge clk);
    wr(8'h08, 32'h0000_0001);
    repeat (4) @(negedge clk);
    measure(256, cnt);
    check("R9 new divide value in use", cnt[0], 64);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule